// File: doc/BRIEF.md
# Master-ID frame access filter

This unit sits between a bus interconnect and a group of memory-mapped peripheral frames. Each access that arrives carries the 4-bit identity of the bus master that issued it and the index of the frame it targets. The unit keeps one 16-bit permission mask per frame, where each bit stands for one master. It passes an access on only when that master's bit is set in the target frame's mask. Any other access is held back. One cycle later the unit raises an error response and reports which master was refused.

The masks are stored in 32-bit configuration registers, and each register covers a pair of frames. Software reaches these registers over a simple register bus that carries a privilege flag. Any caller may read them, but only privileged callers may change them. An unprivileged write leaves the register untouched and is refused with an error in the same cycle. Every mask is cleared at reset, so no master can reach any frame until the masks have been programmed.

Top module: `frame_guard`

## Requirements
- R1: After reset every mask is zero. Every configuration register reads 0 and every access is denied.
- R2: An access is passed (acc_pass_o high, in the same cycle, combinationally) only when req_valid is high and bit req_master of the target frame's mask is 1. Bit i of a mask grants the master whose ID is i. For example, mask 0xAAAA grants the odd IDs and mask 0xCCCC grants IDs 2, 3, 6, 7, 10, 11, 14 and 15.
- R3: Configuration register k holds the mask of frame 2k in bits 15:0 and the mask of frame 2k+1 in bits 31:16.
- R4: A privileged write (cfg_sel, cfg_wr and cfg_priv all high) to an implemented register replaces both of its masks with cfg_wdata from the next clock edge. A 1 sets a mask bit and a 0 clears it. The new masks govern accesses from that next cycle onward.
- R5: An unprivileged write (cfg_sel and cfg_wr high, cfg_priv low) changes no register and drives cfg_err_o high in that same cycle.
- R6: A read (cfg_sel high, cfg_wr low) returns the register contents combinationally on cfg_rdata_o in either privilege mode, with cfg_err_o low.
- R7: A register address at or beyond NUM_FRAMES/2 is unimplemented. Privileged writes to it have no effect and raise no error, and reads of it return 0.
- R8: A frame index at or beyond NUM_FRAMES is always denied, whatever the masks hold.
- R9: In the cycle after a valid access that was denied, acc_err_o is 1 and acc_blk_id_o holds that access's master ID. After a passed access or an idle cycle, acc_err_o is 0 and acc_blk_id_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented |
| req_master | input | 4 | ID of the requesting master |
| req_frame | input | FIDX_W | Index of the target frame |
| acc_pass_o | output | 1 | Access forwarded to the frame (combinational) |
| acc_err_o | output | 1 | Registered error response for a denied access |
| acc_blk_id_o | output | 4 | Master ID of the denied access, registered |
| cfg_sel | input | 1 | Register bus select |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_priv | input | 1 | Caller is privileged |
| cfg_addr | input | CFG_AW | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data (combinational) |
| cfg_err_o | output | 1 | Error on an unprivileged write, same cycle |

## Verification
A corrupted mask bit shows at the ports in two places. The first is on the next read of its register. The second is on acc_pass_o for exactly one master and frame pair, in the same cycle that pair is requested. For this reason the bench sweeps every master against every frame index, including the out-of-range ones, after each change to the configuration. A wrong decision also reaches acc_err_o and acc_blk_id_o one clock later, so the registered response is compared on every access of the sweep. A lost or stray write is exposed by the register reads that follow each write.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam int ID_W   = 4;
    localparam int MASK_W = 1 << ID_W;
    localparam int CFG_DW = 2 * MASK_W;

    typedef struct packed {
        logic            err;
        logic [ID_W-1:0] blk_id;
    } resp_t;
endpackage

// File: rtl/fg_mask_bank.sv
module fg_mask_bank #(
    parameter int NUM_REGS = 3,
    parameter int CFG_AW   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [CFG_AW-1:0]                  wr_idx,
    input  logic [fg_pkg::CFG_DW-1:0]          wr_data,
    output logic [NUM_REGS*fg_pkg::CFG_DW-1:0] regs_flat
);
    import fg_pkg::*;

    typedef struct packed {
        logic [NUM_REGS-1:0][CFG_DW-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (wr_en && (int'(wr_idx) == k)) begin
                st_d.regs[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_flat = st_q.regs;
endmodule

// File: rtl/fg_cfg_port.sv
module fg_cfg_port #(
    parameter int NUM_REGS = 3,
    parameter int CFG_AW   = 2
) (
    input  logic                               cfg_sel,
    input  logic                               cfg_wr,
    input  logic                               cfg_priv,
    input  logic [CFG_AW-1:0]                  cfg_addr,
    input  logic [NUM_REGS*fg_pkg::CFG_DW-1:0] regs_flat,
    output logic                               wr_en,
    output logic [fg_pkg::CFG_DW-1:0]          rdata,
    output logic                               err
);
    import fg_pkg::*;

    logic in_range;

    always_comb begin
        in_range = int'(cfg_addr) < NUM_REGS;
        wr_en    = cfg_sel && cfg_wr && cfg_priv && in_range;
        err      = cfg_sel && cfg_wr && !cfg_priv;
        rdata    = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (cfg_sel && !cfg_wr && (int'(cfg_addr) == k)) begin
                rdata = regs_flat[k*CFG_DW +: CFG_DW];
            end
        end
    end
endmodule

// File: rtl/fg_perm_check.sv
module fg_perm_check #(
    parameter int NUM_FRAMES = 6,
    parameter int FIDX_W     = 3
) (
    input  logic                                 req_valid,
    input  logic [fg_pkg::ID_W-1:0]              req_master,
    input  logic [FIDX_W-1:0]                    req_frame,
    input  logic [NUM_FRAMES*fg_pkg::MASK_W-1:0] mask_flat,
    output logic                                 grant
);
    import fg_pkg::*;

    logic [NUM_FRAMES-1:0] hit;

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        logic [MASK_W-1:0] mask_f;
        assign mask_f = mask_flat[f*MASK_W +: MASK_W];
        assign hit[f] = (int'(req_frame) == f) && mask_f[req_master];
    end

    assign grant = req_valid && (|hit);
endmodule

// File: rtl/fg_resp_reg.sv
module fg_resp_reg (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    grant,
    input  logic [fg_pkg::ID_W-1:0] req_master,
    output logic                    err,
    output logic [fg_pkg::ID_W-1:0] blk_id
);
    import fg_pkg::*;

    resp_t rs_d, rs_q;

    always_comb begin
        rs_d.err    = req_valid && !grant;
        rs_d.blk_id = rs_d.err ? req_master : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign err    = rs_q.err;
    assign blk_id = rs_q.blk_id;
endmodule

// File: rtl/frame_guard.sv
module frame_guard #(
    parameter int NUM_FRAMES = 6,
    parameter int FIDX_W     = 3,
    parameter int CFG_AW     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [fg_pkg::ID_W-1:0] req_master,
    input  logic [FIDX_W-1:0]       req_frame,
    output logic                    acc_pass_o,
    output logic                    acc_err_o,
    output logic [fg_pkg::ID_W-1:0] acc_blk_id_o,
    input  logic                    cfg_sel,
    input  logic                    cfg_wr,
    input  logic                    cfg_priv,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [fg_pkg::CFG_DW-1:0] cfg_wdata,
    output logic [fg_pkg::CFG_DW-1:0] cfg_rdata_o,
    output logic                    cfg_err_o
);
    import fg_pkg::*;

    localparam int NUM_REGS = NUM_FRAMES / 2;

    logic                           wr_en;
    logic [NUM_REGS*CFG_DW-1:0]     regs_flat;
    logic [NUM_FRAMES*MASK_W-1:0]   mask_flat;

    // Register k packs frame 2k low and frame 2k+1 high, so the flat
    // register image is the flat per-frame mask image.
    assign mask_flat = regs_flat;

    fg_cfg_port #(.NUM_REGS(NUM_REGS), .CFG_AW(CFG_AW)) u_cfg (
        .cfg_sel  (cfg_sel),
        .cfg_wr   (cfg_wr),
        .cfg_priv (cfg_priv),
        .cfg_addr (cfg_addr),
        .regs_flat(regs_flat),
        .wr_en    (wr_en),
        .rdata    (cfg_rdata_o),
        .err      (cfg_err_o)
    );

    fg_mask_bank #(.NUM_REGS(NUM_REGS), .CFG_AW(CFG_AW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (cfg_addr),
        .wr_data  (cfg_wdata),
        .regs_flat(regs_flat)
    );

    fg_perm_check #(.NUM_FRAMES(NUM_FRAMES), .FIDX_W(FIDX_W)) u_perm (
        .req_valid (req_valid),
        .req_master(req_master),
        .req_frame (req_frame),
        .mask_flat (mask_flat),
        .grant     (acc_pass_o)
    );

    fg_resp_reg u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .grant     (acc_pass_o),
        .req_master(req_master),
        .err       (acc_err_o),
        .blk_id    (acc_blk_id_o)
    );
endmodule

// File: rtl/frame_guard_checker.sv
module frame_guard_checker #(
    parameter int NUM_FRAMES = 6,
    parameter int FIDX_W     = 3,
    parameter int CFG_AW     = 2
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 req_valid,
    input logic [fg_pkg::ID_W-1:0]              req_master,
    input logic [FIDX_W-1:0]                    req_frame,
    input logic                                 acc_pass_o,
    input logic                                 acc_err_o,
    input logic [fg_pkg::ID_W-1:0]              acc_blk_id_o,
    input logic                                 cfg_sel,
    input logic                                 cfg_wr,
    input logic                                 cfg_priv,
    input logic [CFG_AW-1:0]                    cfg_addr,
    input logic [fg_pkg::CFG_DW-1:0]            cfg_wdata,
    input logic [fg_pkg::CFG_DW-1:0]            cfg_rdata_o,
    input logic                                 cfg_err_o,
    input logic [NUM_FRAMES*fg_pkg::MASK_W-1:0] mask_flat
);
    import fg_pkg::*;

    localparam int NUM_REGS = NUM_FRAMES / 2;

    function automatic logic mask_bit(input int f, input int m);
        logic r;
        r = 1'b0;
        for (int k = 0; k < NUM_FRAMES * MASK_W; k++) begin
            if (f < NUM_FRAMES && k == f * MASK_W + m) r = mask_flat[k];
        end
        return r;
    endfunction

    function automatic logic [CFG_DW-1:0] reg_val(input int a);
        logic [CFG_DW-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (k == a) r = mask_flat[k*CFG_DW +: CFG_DW];
        end
        return r;
    endfunction

    p_pass_needs_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pass_o |-> req_valid && mask_bit(int'(req_frame), int'(req_master)));

    p_bit_gives_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mask_bit(int'(req_frame), int'(req_master))) |-> acc_pass_o);

    p_oob_frame_denied_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req_frame) >= NUM_FRAMES) |-> !acc_pass_o);

    p_priv_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_wr && cfg_priv && int'(cfg_addr) < NUM_REGS)
        |=> reg_val(int'($past(cfg_addr))) == $past(cfg_wdata));

    p_user_write_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_wr && !cfg_priv) |-> cfg_err_o);

    p_user_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_wr && !cfg_priv) |=> $stable(mask_flat));

    p_read_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && !cfg_wr) |-> !cfg_err_o);

    p_unimpl_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && !cfg_wr && int'(cfg_addr) >= NUM_REGS) |-> cfg_rdata_o == '0);

    p_deny_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !acc_pass_o) |=> acc_err_o && acc_blk_id_o == $past(req_master));

    p_no_stray_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !acc_pass_o) |=> !acc_err_o && acc_blk_id_o == '0);
endmodule

bind frame_guard frame_guard_checker #(
    .NUM_FRAMES(NUM_FRAMES),
    .FIDX_W    (FIDX_W),
    .CFG_AW    (CFG_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_master  (req_master),
    .req_frame   (req_frame),
    .acc_pass_o  (acc_pass_o),
    .acc_err_o   (acc_err_o),
    .acc_blk_id_o(acc_blk_id_o),
    .cfg_sel     (cfg_sel),
    .cfg_wr      (cfg_wr),
    .cfg_priv    (cfg_priv),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata_o (cfg_rdata_o),
    .cfg_err_o   (cfg_err_o),
    .mask_flat   (mask_flat)
);

// File: tb/frame_guard_bench.sv
module frame_guard_bench;
    localparam int NF   = 6;
    localparam int NREG = NF / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_master = '0;
    logic [2:0]  req_frame = '0;
    logic        acc_pass_o, acc_err_o;
    logic [3:0]  acc_blk_id_o;
    logic        cfg_sel = 1'b0, cfg_wr = 1'b0, cfg_priv = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata_o;
    logic        cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mdl [0:7];

    always #10 clk = ~clk;

    frame_guard #(.NUM_FRAMES(NF), .FIDX_W(3), .CFG_AW(2)) u_frame_guard (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_master(req_master), .req_frame(req_frame),
        .acc_pass_o(acc_pass_o), .acc_err_o(acc_err_o), .acc_blk_id_o(acc_blk_id_o),
        .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_priv(cfg_priv),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata_o(cfg_rdata_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // R4 R5 R7: write with model update
    task automatic cfg_write(input int a, input logic [31:0] d, input logic priv);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_priv = priv;
        cfg_addr = 2'(a); cfg_wdata = d;
        #2;
        chk(priv ? "R4/R7 cfg_err on privileged write" : "R5 cfg_err on user write",
            32'(cfg_err_o), 32'(!priv));
        @(negedge clk);
        cfg_sel = 1'b0; cfg_wr = 1'b0;
        if (priv && a < NREG) begin
            mdl[2*a]   = d[15:0];
            mdl[2*a+1] = d[31:16];
        end
    endtask

    // R3 R6 R7: read in a given mode
    task automatic cfg_read(input int a, input logic priv);
        logic [31:0] exp;
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b0; cfg_priv = priv; cfg_addr = 2'(a);
        exp = (a < NREG) ? {mdl[2*a+1], mdl[2*a]} : 32'h0;
        #2;
        chk((a < NREG) ? "R3/R6 read data" : "R7 unimplemented read", cfg_rdata_o, exp);
        chk("R6 no error on read", 32'(cfg_err_o), 32'h0);
        cfg_sel = 1'b0;
    endtask

    // R2 R8 R9: one access and its registered response
    task automatic access(input int f, input int m, input logic v);
        logic exp_pass;
        @(negedge clk);
        req_valid = v; req_frame = 3'(f); req_master = 4'(m);
        exp_pass = v && (f < NF) && mdl[f][m];
        #2;
        chk((f < NF) ? "R2 pass decision" : "R8 out-of-range frame", 32'(acc_pass_o), 32'(exp_pass));
        @(negedge clk);
        chk("R9 error response", 32'(acc_err_o), 32'(v && !exp_pass));
        chk("R9 blocked id", 32'(acc_blk_id_o), (v && !exp_pass) ? 32'(m) : 32'h0);
        req_valid = 1'b0;
    endtask

    task automatic sweep();
        for (int f = 0; f < 8; f++) begin
            for (int m = 0; m < 16; m++) begin
                access(f, m, 1'b1);
            end
        end
        access(0, 5, 1'b0);
    endtask

    task automatic read_all(input logic priv);
        for (int a = 0; a < 4; a++) cfg_read(a, priv);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 err after reset", 32'(acc_err_o), 32'h0);
        read_all(1'b0);
        read_all(1'b1);
        sweep();
        // R4: odd and pair patterns, privileged
        cfg_write(0, 32'hCCCC_AAAA, 1'b1);
        cfg_write(1, 32'h8001_FFFF, 1'b1);
        cfg_write(2, 32'h0001_7E00, 1'b1);
        read_all(1'b0);
        sweep();
        // R5: user write refused
        cfg_write(0, 32'hFFFF_FFFF, 1'b0);
        cfg_write(2, 32'h0000_0000, 1'b0);
        read_all(1'b1);
        sweep();
        // R7: unimplemented register
        cfg_write(3, 32'hFFFF_FFFF, 1'b1);
        read_all(1'b1);
        sweep();
        // R4: clearing bits
        cfg_write(0, 32'h1234_0000, 1'b1);
        cfg_write(1, 32'h0000_8000, 1'b1);
        read_all(1'b0);
        sweep();
        summary();
        $finish;
    end
endmodule